// File: doc/BRIEF.md
# Timebase, Capture and Watchdog Timer

This block is a small timing peripheral for a microcontroller-class subsystem. An internal up-counter, eight bits wide by default, advances once every `DIV` clock cycles. Software can neither read nor write it. Each time the counter wraps it can raise a timebase flag, either on every wrap or on every second wrap. An edge on the capture pin copies the counter into a capture register and raises a capture flag. Either flag can request an interrupt when its enable bit is set.

The same wrap stream drives a watchdog. Once software arms it, software must set a refresh bit within every watchdog period. Hardware clears that bit at the end of each period. If a period ends while the bit is already clear, the block drives a reset pulse of fixed length.

Software reaches the block through a two-register bus. Address 0 holds the control/status byte. Address 1 holds the read-only capture byte. Read data is combinational and is valid in the same cycle as the read strobe. Read side effects take place at the clock edge that ends the read cycle.

Top module: `tbw_timer`

## Requirements
- R1: After reset the control byte and the capture byte both read 0x00, `irq_o` is low and `wd_rst_o` is low.
- R2: After n rising clock edges since reset release, the hidden counter holds floor(n/DIV) mod 2^CNT_W. A write to address 1 does not change the capture byte.
- R3: With control bit 0 (period select) at 0, every counter wrap sets the timebase flag (control bit 2). The flag is set on edge n = k*DIV*2^CNT_W.
- R4: With control bit 0 at 1, only even-numbered wraps (k = 2, 4, 6, ...) set the timebase flag.
- R5: Reading address 0 clears both flags at the edge that ends the read. If a flag-setting event falls on that same edge, the flag stays set.
- R6: A change on `cap_pin_i` is sampled at edge m and passes through two synchronising flops. At edge m+2 the block latches the counter value from before that edge, floor((m+1)/DIV) mod 2^CNT_W, into the capture byte and sets the capture flag (control bit 4). By default both rising and falling edges trigger a capture.
- R7: Reading address 1 returns the capture byte unchanged and clears the capture flag.
- R8: `irq_o` is high exactly when (timebase flag AND control bit 1) OR (capture flag AND control bit 3).
- R9: Writing 1 to control bit 5 arms the watchdog. Writing 0 to it has no effect. Only reset disarms it.
- R10: Writing 1 to control bit 6 sets the refresh bit. Hardware clears it at every watchdog period end, which falls on every WD_OVF-th wrap, at edge n = j*WD_OVF*DIV*2^CNT_W.
- R11: If a period end occurs while the watchdog is armed and the refresh bit is clear, `wd_rst_o` is high for RST_PULSE cycles starting after that edge. If the refresh bit is set at that moment, no pulse occurs.
- R12: While the watchdog is not armed, `wd_rst_o` never rises.
- R13: Writes to the flag bits (2 and 4) and to bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 1 | 0 selects the control byte, 1 selects the capture byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| irq_o | output | 1 | Interrupt request |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench keeps its own count of edges since reset release. It derives every due cycle from that count:
- Timebase flags appear on the edge that is a multiple of DIV*256.
- A capture shows up three edges after the pin change is driven.
- The watchdog pulse starts on the period-end edge and drops RST_PULSE edges later.

Every output is sampled at the falling edge following the edge on which it is due. The sample taken one edge earlier is also checked, so a value that arrives a cycle early or a cycle late is reported. One read is deliberately placed on the same edge as a timebase event to exercise the set-over-clear rule.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
   localparam int REG_W       = 8;
   localparam int CTL_TB_SEL  = 0;
   localparam int CTL_TB_IE   = 1;
   localparam int CTL_TB_FLG  = 2;
   localparam int CTL_CAP_IE  = 3;
   localparam int CTL_CAP_FLG = 4;
   localparam int CTL_WD_EN   = 5;
   localparam int CTL_WD_REF  = 6;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_sel_e;
endpackage

// File: rtl/tbw_timebase.sv
module tbw_timebase #(
   parameter int CNT_W = 8,
   parameter int DIV   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_sel_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             tb_evt_o
);
   localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   initial begin
      assert (DIV >= 2) else $error("DIV must be at least 2");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
   end

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             half_q;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         assign tick = &pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_q + PRE_W'(1);
         end
      end else begin : g_mod
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
         assign tick = (pre_q == PRE_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pre_q <= '0;
            else if (tick) pre_q <= '0;
            else           pre_q <= pre_q + PRE_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == CNT_LAST) half_q <= ~half_q;
      end
   end

   assign cnt_o    = cnt_q;
   assign wrap_o   = tick && (cnt_q == CNT_LAST);
   assign tb_evt_o = wrap_o && (!tb_sel_i || half_q);

   // R2: counter only moves on a prescaler tick, by exactly one
   a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   // R4: the half-rate phase flips on each wrap
   a_r4_half_flip: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> half_q != $past(half_q));
endmodule

// File: rtl/tbw_capture.sv
module tbw_capture
   import tbw_pkg::*;
#(
   parameter int        CNT_W     = 8,
   parameter edge_sel_e EDGE_MODE = EDGE_BOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] cap_o,
   output logic             cap_evt_o
);
   logic s1_q, s2_q, prev_q;
   logic [CNT_W-1:0] cap_q;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         s1_q   <= pin_i;
         s2_q   <= s1_q;
         prev_q <= s2_q;
      end
   end

   generate
      if (EDGE_MODE == EDGE_RISE) begin : g_rise
         assign hit = s2_q && !prev_q;
      end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
         assign hit = !s2_q && prev_q;
      end else begin : g_both
         assign hit = s2_q ^ prev_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_q <= '0;
      else if (hit) cap_q <= cnt_i;
   end

   assign cap_o     = cap_q;
   assign cap_evt_o = hit;

   // R6: a capture stores the counter seen at that edge; otherwise the byte holds
   a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> cap_q == $past(cnt_i));
   a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_q));
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
   parameter int WD_OVF    = 2,
   parameter int RST_PULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic en_set_i,
   input  logic ref_set_i,
   output logic en_o,
   output logic ref_o,
   output logic wd_rst_o
);
   localparam int PW = $clog2(RST_PULSE + 1);

   initial begin
      assert (WD_OVF >= 1) else $error("WD_OVF must be at least 1");
      assert (RST_PULSE >= 1) else $error("RST_PULSE must be at least 1");
   end

   logic period_end;
   logic en_q, ref_q, fire;
   logic [PW-1:0] pls_q;

   generate
      if (WD_OVF == 1) begin : g_every
         assign period_end = wrap_i;
      end else begin : g_count
         localparam int WW = $clog2(WD_OVF);
         localparam logic [WW-1:0] W_LAST = WW'(WD_OVF - 1);
         logic [WW-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wcnt_q <= '0;
            else if (wrap_i) wcnt_q <= (wcnt_q == W_LAST) ? '0 : wcnt_q + WW'(1);
         end
         assign period_end = wrap_i && (wcnt_q == W_LAST);
      end
   endgenerate

   assign fire = period_end && en_q && !ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ref_q <= 1'b0;
         pls_q <= '0;
      end else begin
         if (en_set_i) en_q <= 1'b1;
         if (ref_set_i)       ref_q <= 1'b1;
         else if (period_end) ref_q <= 1'b0;
         if (fire)                pls_q <= PW'(RST_PULSE);
         else if (pls_q != '0)    pls_q <= pls_q - PW'(1);
      end
   end

   assign en_o     = en_q;
   assign ref_o    = ref_q;
   assign wd_rst_o = (pls_q != '0);

   // R9: arming is sticky until reset
   a_r9_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
   // R10: refresh bit is consumed at the period end
   a_r10_ref_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && !ref_set_i) |=> !ref_q);
   // R11: expiry with no refresh raises the reset output
   a_r11_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && en_q && !ref_q) |=> wd_rst_o);
   // R12: never a reset while disarmed
   a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !wd_rst_o);
endmodule

// File: rtl/tbw_timer.sv
module tbw_timer
   import tbw_pkg::*;
#(
   parameter int        CNT_W     = 8,
   parameter int        DIV       = 32,
   parameter int        WD_OVF    = 2,
   parameter int        RST_PULSE = 4,
   parameter edge_sel_e EDGE_MODE = EDGE_BOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_rd_i,
   input  logic             reg_wr_i,
   input  logic             reg_addr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   input  logic             cap_pin_i,
   output logic             irq_o,
   output logic             wd_rst_o
);
   initial begin
      assert (CNT_W <= REG_W) else $error("CNT_W exceeds register width");
   end

   logic [CNT_W-1:0] cnt, cap_val;
   logic wrap, tb_evt, cap_evt;
   logic tb_sel_q, tb_ie_q, cap_ie_q, tb_flg_q, cap_flg_q;
   logic wd_en, wd_ref;
   logic wr_ctl, rd_ctl, rd_cap;
   logic unused_wbits;

   assign wr_ctl = reg_wr_i && (reg_addr_i == 1'b0);
   assign rd_ctl = reg_rd_i && (reg_addr_i == 1'b0);
   assign rd_cap = reg_rd_i && (reg_addr_i == 1'b1);
   assign unused_wbits = ^{reg_wdata_i[7], reg_wdata_i[CTL_CAP_FLG], reg_wdata_i[CTL_TB_FLG]};

   tbw_timebase #(.CNT_W(CNT_W), .DIV(DIV)) u_tb (
      .clk(clk), .rst_n(rst_n), .tb_sel_i(tb_sel_q),
      .cnt_o(cnt), .wrap_o(wrap), .tb_evt_o(tb_evt));

   tbw_capture #(.CNT_W(CNT_W), .EDGE_MODE(EDGE_MODE)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .cnt_i(cnt),
      .cap_o(cap_val), .cap_evt_o(cap_evt));

   tbw_watchdog #(.WD_OVF(WD_OVF), .RST_PULSE(RST_PULSE)) u_wd (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
      .en_set_i(wr_ctl && reg_wdata_i[CTL_WD_EN]),
      .ref_set_i(wr_ctl && reg_wdata_i[CTL_WD_REF]),
      .en_o(wd_en), .ref_o(wd_ref), .wd_rst_o(wd_rst_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_sel_q  <= 1'b0;
         tb_ie_q   <= 1'b0;
         cap_ie_q  <= 1'b0;
         tb_flg_q  <= 1'b0;
         cap_flg_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            tb_sel_q <= reg_wdata_i[CTL_TB_SEL];
            tb_ie_q  <= reg_wdata_i[CTL_TB_IE];
            cap_ie_q <= reg_wdata_i[CTL_CAP_IE];
         end
         if (tb_evt)      tb_flg_q <= 1'b1;
         else if (rd_ctl) tb_flg_q <= 1'b0;
         if (cap_evt)               cap_flg_q <= 1'b1;
         else if (rd_ctl || rd_cap) cap_flg_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == 1'b0) begin
         reg_rdata_o[CTL_TB_SEL]  = tb_sel_q;
         reg_rdata_o[CTL_TB_IE]   = tb_ie_q;
         reg_rdata_o[CTL_TB_FLG]  = tb_flg_q;
         reg_rdata_o[CTL_CAP_IE]  = cap_ie_q;
         reg_rdata_o[CTL_CAP_FLG] = cap_flg_q;
         reg_rdata_o[CTL_WD_EN]   = wd_en;
         reg_rdata_o[CTL_WD_REF]  = wd_ref;
      end else begin
         reg_rdata_o = REG_W'(cap_val);
      end
   end

   assign irq_o = (tb_flg_q && tb_ie_q) || (cap_flg_q && cap_ie_q);

   // R3: a timebase event always leaves the flag set (also over a read, R5)
   a_r3_tb_set: assert property (@(posedge clk) disable iff (!rst_n)
      tb_evt |=> tb_flg_q);
   // R5: a control read with no event clears the timebase flag
   a_r5_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctl && !tb_evt) |=> !tb_flg_q);
   // R6: capture raises its flag
   a_r6_cap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_flg_q);
   // R7: capture-byte read clears the capture flag and keeps the byte
   a_r7_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cap && !cap_evt) |=> (!cap_flg_q && $stable(cap_val)));
endmodule

// File: tb/tbw_timer_tb.sv
`timescale 1ns/1ps
module tbw_timer_tb_top;
   localparam int DIV  = 4;
   localparam int WRAP = 256 * DIV;
   localparam int WDP  = 2 * WRAP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd = 1'b0, wr = 1'b0, addr = 1'b0, pin = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic irq, wdr;
   int cyc = 0;
   int n_chk = 0, n_bad = 0;
   int early_rst = 0;
   bit done = 0;

   tbw_timer #(.CNT_W(8), .DIV(DIV), .WD_OVF(2), .RST_PULSE(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_rd_i(rd), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .cap_pin_i(pin), .irq_o(irq), .wd_rst_o(wdr));

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else begin
         cyc <= cyc + 1;
         if (wdr && cyc < 12280) early_rst <= early_rst + 1;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (cyc %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      check("R1", "wd_rst after reset", wdr, 0);
      check("R1", "irq after reset", irq, 0);
      rd_reg(1'b0, d); check("R1", "ctrl after reset", d, 8'h00);
      rd_reg(1'b1, d); check("R1", "capture after reset", d, 8'h00);
   endtask

   task automatic t_timebase_every();
      logic [7:0] d;
      wait_until(WRAP - 4);
      rd_reg(1'b0, d); check("R3", "flag before first wrap", d[2], 0);
      wait_until(WRAP);
      rd_reg(1'b0, d); check("R3", "flag at first wrap", d[2], 1);
      rd_reg(1'b0, d); check("R5", "flag cleared by read", d[2], 0);
      wait_until(2 * WRAP - 1);
      rd_reg(1'b0, d); check("R5", "flag before coincident edge", d[2], 0);
      rd_reg(1'b0, d); check("R5", "event wins over read clear", d[2], 1);
      wr_reg(1'b0, 8'h02);
      wait_until(3 * WRAP - 1);
      check("R8", "irq before wrap", irq, 0);
      wait_until(3 * WRAP);
      check("R8", "irq with flag and enable", irq, 1);
      rd_reg(1'b0, d); check("R3", "ctrl at third wrap", d, 8'h06);
      check("R8", "irq after flag read", irq, 0);
   endtask

   task automatic t_timebase_half();
      logic [7:0] d;
      wr_reg(1'b0, 8'h95);
      rd_reg(1'b0, d); check("R13", "flag bits not writable", d, 8'h01);
      wait_until(4 * WRAP);
      rd_reg(1'b0, d); check("R4", "flag on even wrap 4", d[2], 1);
      wait_until(5 * WRAP + 1);
      rd_reg(1'b0, d); check("R4", "no flag on odd wrap 5", d[2], 0);
      wait_until(6 * WRAP);
      rd_reg(1'b0, d); check("R4", "flag on even wrap 6", d[2], 1);
   endtask

   task automatic t_capture();
      logic [7:0] d, e;
      int c;
      wr_reg(1'b0, 8'h09);
      wait_until(6 * WRAP + 60);
      c = cyc; pin = 1'b1; e = 8'(((c + 2) / DIV) % 256);
      @(negedge clk); @(negedge clk);
      check("R6", "irq one edge before capture", irq, 0);
      @(negedge clk);
      check("R6", "irq at capture edge", irq, 1);
      rd_reg(1'b1, d); check("R6", "rising capture value", d, e);
      check("R7", "irq cleared by capture read", irq, 0);
      wait_until(6 * WRAP + 150);
      c = cyc; pin = 1'b0; e = 8'(((c + 2) / DIV) % 256);
      repeat (3) @(negedge clk);
      rd_reg(1'b0, d); check("R6", "capture flag on falling edge", d[4], 1);
      check("R5", "ctrl read clears capture irq", irq, 0);
      rd_reg(1'b1, d); check("R6", "falling capture value", d, e);
      rd_reg(1'b1, d); check("R7", "capture unchanged by read", d, e);
      wr_reg(1'b1, 8'hAA);
      rd_reg(1'b1, d); check("R2", "capture byte not writable", d, e);
   endtask

   task automatic t_watchdog();
      logic [7:0] d;
      check("R12", "no reset while disarmed", early_rst, 0);
      wait_until(7000);
      wr_reg(1'b0, 8'h60);
      wait_until(4 * WDP - 2);
      rd_reg(1'b0, d); check("R10", "refresh bit set", d[6], 1);
      wait_until(4 * WDP + 1);
      check("R11", "no reset when refreshed", wdr, 0);
      rd_reg(1'b0, d); check("R10", "refresh cleared at period end", d[6], 0);
      check("R9", "armed after period", d[5], 1);
      wr_reg(1'b0, 8'h00);
      rd_reg(1'b0, d); check("R9", "write 0 does not disarm", d[5], 1);
      wait_until(9000);
      wr_reg(1'b0, 8'h40);
      wait_until(5 * WDP + 4);
      rd_reg(1'b0, d); check("R10", "second refresh consumed", d[6], 0);
      check("R11", "no early reset", early_rst, 0);
      wait_until(6 * WDP - 1);
      check("R11", "reset low before expiry", wdr, 0);
      wait_until(6 * WDP);
      check("R11", "reset rises at expiry", wdr, 1);
      wait_until(6 * WDP + 3);
      check("R11", "reset still high at pulse end", wdr, 1);
      wait_until(6 * WDP + 4);
      check("R11", "reset falls after pulse", wdr, 0);
   endtask

   task automatic t_rearm_reset();
      logic [7:0] d;
      do_reset();
      check("R1", "wd_rst after second reset", wdr, 0);
      rd_reg(1'b0, d); check("R9", "reset disarms watchdog", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_timebase_every();
      t_timebase_half();
      t_capture();
      t_watchdog();
      t_rearm_reset();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule